// File: doc/BRIEF.md
# I2C Register-File Slave

This block is a two-wire bus slave that lets a host read and write a bank of twenty-one 8-bit control registers, numbered 00h to 14h. A fast system clock oversamples the SCL and SDA lines. The block finds start, repeated-start and stop conditions and moves each byte most significant bit first. It answers one 7-bit device address. The lowest bit of that address comes from an external select pin, so two of these slaves can share one bus.

A write transaction first loads a register pointer from the byte that follows the device address. Each later data byte goes to the pointer and then moves the pointer up by one. The pointer stops at the top register and stays there. A read transaction sends data from wherever an earlier write left the pointer. The block's outputs are the full register contents and one enable that pulls the open-drain SDA line low.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and it begins an address phase from any state. A stop is SDA rising while SCL is high, and it returns the block to idle with SDA released. Clock pulses sent with no start before them are not acknowledged and change no register.
- R2: The first byte after a start is a 7-bit device address followed by a direction bit (1 = read, 0 = write). The device address is 1001100 with the LSB replaced by `addr_sel_i`. On a match, the slave holds SDA low through the 9th SCL pulse.
- R3: On a device-address mismatch, the slave never pulls SDA low and ignores the bus until the next start or stop. No register changes.
- R4: Every byte is shifted MSB first, in both directions.
- R5: In a write, the byte after the device address loads the pointer. Each following data byte is stored at the pointer, and the pointer then increments by one. The slave acknowledges every accepted byte.
- R6: A write burst that runs past 14h keeps the pointer at 14h, and each extra byte overwrites register 14h.
- R7: A pointer byte greater than 14h gets no acknowledge, and the rest of that transaction writes nothing.
- R8: A read returns the register at the current pointer and increments the pointer after each byte. While sending, the slave pulls SDA low only for 0 bits.
- R9: During a read, the pointer also saturates at 14h, so register 14h is returned again.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next start or stop.
- R11: A repeated start ends the current transfer and begins a new address phase. The pointer keeps its value.
- R12: The SDA drive enable changes only in the cycle after a detected SCL falling edge, start or stop. It never changes while SCL is high.
- R13: A synchronous reset clears every register and the pointer to 00h and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel_i | input | 1 | Supplies the LSB of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | All register contents; register k is in bits k*8+7 down to k*8 |

## Verification
The heaviest overlap is on a single SCL falling edge inside a burst that reaches 14h. On that edge, the data byte is stored at the pointer, the pointer either saturates or increments, and the acknowledge drive turns on. A burst that starts at 13h provokes this. The bench then checks that register 13h keeps the first byte and that register 14h holds the last one. A second overlap happens when a repeated start arrives right after an acknowledge: the address phase restarts while the pointer must survive. A repeated-start read checks this by comparing the returned bytes against the pointer left by the write.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } link_st_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_prev;
        logic              sda_prev;
    } sync_s;

    sync_s q, d;
    logic scl_now, sda_now;

    assign scl_now = q.scl_p[STAGES-1];
    assign sda_now = q.sda_p[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_p    = {q.scl_p[STAGES-2:0], scl_i};
        d.sda_p    = {q.sda_p[STAGES-2:0], sda_i};
        d.scl_prev = scl_now;
        d.sda_prev = sda_now;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= d;
    end

    assign scl_rise_o = scl_now & ~q.scl_prev;
    assign scl_fall_o = ~scl_now & q.scl_prev;
    assign start_o    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;
    assign sda_o      = sda_now;

    // R1: bus conditions are only flagged with SCL held high across both samples
    p_cond_scl_high_r1: assert property (@(posedge clk) disable iff (rst)
        (start_o || stop_o) |-> (scl_now && $past(scl_now)));
endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank #(
    parameter int NUM_REGS = 21,
    parameter int ADDR_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     waddr_i,
    input  logic [7:0]            wdata_i,
    input  logic [ADDR_W-1:0]     raddr_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] regs_q [NUM_REGS];
    logic [7:0] regs_d [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we_i && (32'(waddr_i) < NUM_REGS)) regs_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= 8'h00;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = (32'(raddr_i) < NUM_REGS) ? regs_q[raddr_i] : 8'h00;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign regs_o[g*8 +: 8] = regs_q[g];

        // R5: a register moves only after a write aimed at it
        p_write_gate_r5: assert property (@(posedge clk) disable iff (rst)
            !$stable(regs_q[g]) |-> $past(we_i && (waddr_i == ADDR_W'(g))));
    end
endmodule

// File: rtl/i2c_rf_link.sv
module i2c_rf_link
    import i2c_rf_pkg::*;
#(
    parameter int         NUM_REGS = 21,
    parameter int         ADDR_W   = 5,
    parameter logic [6:0] DEV_ADDR = 7'b1001100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] PTR_MAX  = ADDR_W'(NUM_REGS - 1);
    localparam logic [7:0]        BASE_MAX = 8'(NUM_REGS - 1);

    typedef struct packed {
        link_st_e          st;
        logic [3:0]        cnt;
        logic [7:0]        shreg;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              nack;
    } link_s;

    link_s q, d;
    logic  we_d;
    logic [ADDR_W-1:0] ptr_inc;

    assign ptr_inc = (q.ptr == PTR_MAX) ? q.ptr : q.ptr + 1'b1;

    always_comb begin
        d    = q;
        we_d = 1'b0;
        if (start_i) begin
            d.st  = ST_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (stop_i) begin
            d.st  = ST_IDLE;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (q.st != ST_IDLE && q.st != ST_SKIP) begin
            if (scl_rise_i) begin
                if (q.cnt < 4'd8 && q.st != ST_RDATA) d.shreg = {q.shreg[6:0], sda_i};
                if (q.cnt == 4'd8 && q.st == ST_RDATA) d.nack = sda_i;
                if (q.cnt < 4'd9) d.cnt = q.cnt + 4'd1;
            end else if (scl_fall_i) begin
                if (q.cnt == 4'd8) begin
                    unique case (q.st)
                        ST_ADDR: begin
                            if (q.shreg[7:1] == {DEV_ADDR[6:1], addr_sel_i}) begin
                                d.oe   = 1'b1;
                                d.nack = 1'b0;
                                d.st   = q.shreg[0] ? ST_RDATA : ST_REG;
                            end else begin
                                d.st = ST_SKIP;
                                d.oe = 1'b0;
                            end
                        end
                        ST_REG: begin
                            if (q.shreg <= BASE_MAX) begin
                                d.ptr = q.shreg[ADDR_W-1:0];
                                d.oe  = 1'b1;
                                d.st  = ST_WDATA;
                            end else begin
                                d.st = ST_SKIP;
                                d.oe = 1'b0;
                            end
                        end
                        ST_WDATA: begin
                            we_d  = 1'b1;
                            d.ptr = ptr_inc;
                            d.oe  = 1'b1;
                        end
                        ST_RDATA: begin
                            d.oe  = 1'b0;
                            d.ptr = ptr_inc;
                        end
                        default: ;
                    endcase
                end else if (q.cnt == 4'd9) begin
                    d.cnt = 4'd0;
                    d.oe  = 1'b0;
                    if (q.st == ST_RDATA) begin
                        if (q.nack) begin
                            d.st = ST_SKIP;
                        end else begin
                            d.shreg = rd_data_i;
                            d.oe    = ~rd_data_i[7];
                        end
                    end
                end else if (q.cnt != 4'd0 && q.st == ST_RDATA) begin
                    d.shreg = {q.shreg[6:0], 1'b0};
                    d.oe    = ~q.shreg[6];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_IDLE;
            q.cnt   <= 4'd0;
            q.shreg <= 8'h00;
            q.ptr   <= '0;
            q.oe    <= 1'b0;
            q.nack  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign wr_en_o   = we_d;
    assign wr_addr_o = q.ptr;
    assign wr_data_o = q.shreg;
    assign ptr_o     = q.ptr;

    // R3 / R10: an ignoring or idle slave keeps SDA released
    p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE || q.st == ST_SKIP) |-> !q.oe);

    // R12: drive changes only follow an SCL fall or a bus condition
    p_oe_after_fall_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.oe) |-> $past(scl_fall_i || start_i || stop_i));

    // R6 / R9: pointer never leaves the register range
    p_ptr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        q.ptr <= PTR_MAX);

    // R5: outside the pointer-load phase, the pointer only steps by one
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(q.ptr) && $past(q.st) != ST_REG) |-> (q.ptr == ADDR_W'($past(q.ptr) + 1'b1)));

    // R11: any start restarts the address phase at bit zero
    p_start_restarts_r11: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (q.st == ST_ADDR && q.cnt == 4'd0 && !q.oe));
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
    parameter int         NUM_REGS    = 21,
    parameter logic [6:0] DEV_ADDR    = 7'b1001100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_sel_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int ADDR_W = $clog2(NUM_REGS);

    logic              scl_rise, scl_fall, start_c, stop_c, sda_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, ptr;
    logic [7:0]        wr_data, rd_data;

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c),
        .sda_o      (sda_s)
    );

    i2c_rf_link #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk        (clk),
        .rst        (rst),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .sda_i      (sda_s),
        .addr_sel_i (addr_sel_i),
        .rd_data_i  (rd_data),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .ptr_o      (ptr)
    );

    i2c_rf_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .raddr_i (ptr),
        .rdata_o (rd_data),
        .regs_o  (regs_o)
    );
endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
    localparam int NREG = 21;
    localparam int T    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sel = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    logic prev_oe = 1'b0;
    logic done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regfile_slave u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .addr_sel_i (sel),
        .sda_oe_o   (sda_oe),
        .regs_o     (regs)
    );

    // R12 monitor: drive enable must not move while the master holds SCL high
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe !== prev_oe && m_scl) viol++;
            prev_oe = sda_oe;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rg(input int k);
        return regs[k*8 +: 8];
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b0; wt(T);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b1; wt(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(T);
            m_scl = 1'b1; wt(T);
            m_scl = 1'b0; wt(T);
        end
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T/2);
        acked = (sda_line == 1'b0);
        wt(T/2);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wt(T);
            m_scl = 1'b1; wt(T/2);
            b = {b[6:0], sda_line};
            wt(T/2);
            m_scl = 1'b0;
        end
        wt(T);
        m_sda = give_ack ? 1'b0 : 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        m_scl = 1'b0; wt(T);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        logic any;
        any = 1'b0;
        for (int k = 0; k < NREG; k++) if (rg(k) != 8'h00) any = 1'b1;
        chk("R13 registers clear after reset", any, 0);
        chk("R13 SDA released after reset", sda_oe, 0);
    endtask

    task automatic t_burst_write();
        logic a0, a1, a2, a3, a4;
        bus_start();
        send_byte(8'h98, a0);
        send_byte(8'h02, a1);
        send_byte(8'hA5, a2);
        send_byte(8'h3C, a3);
        send_byte(8'h0F, a4);
        bus_stop();
        chk("R2 device address acknowledged", a0, 1);
        chk("R5 pointer byte acknowledged", a1, 1);
        chk("R5 data bytes acknowledged", {a2, a3, a4}, 3'b111);
        chk("R4 MSB-first byte at 02h", rg(2), 8'hA5);
        chk("R5 increment to 03h", rg(3), 8'h3C);
        chk("R5 increment to 04h", rg(4), 8'h0F);
        chk("R5 neighbours untouched", {rg(1), rg(5)}, 16'h0000);
        chk("R1 SDA released after stop", sda_oe, 0);
    endtask

    task automatic t_no_start();
        logic a0, a1, a2;
        send_byte(8'h98, a0);
        send_byte(8'h01, a1);
        send_byte(8'h55, a2);
        chk("R1 no acknowledge without start", {a0, a1, a2}, 3'b000);
        chk("R1 no write without start", rg(1), 8'h00);
    endtask

    task automatic t_select();
        logic a0, a1, a2;
        sel = 1'b1; wt(T);
        bus_start();
        send_byte(8'h98, a0);
        send_byte(8'h05, a1);
        send_byte(8'hEE, a2);
        bus_stop();
        chk("R3 mismatched address gets no acknowledge", {a0, a1, a2}, 3'b000);
        chk("R3 mismatched transaction writes nothing", rg(5), 8'h00);
        bus_start();
        send_byte(8'h9A, a0);
        send_byte(8'h05, a1);
        send_byte(8'hEE, a2);
        bus_stop();
        chk("R2 select pin supplies address LSB", {a0, a1, a2}, 3'b111);
        chk("R2 write through selected address", rg(5), 8'hEE);
        sel = 1'b0; wt(T);
    endtask

    task automatic t_saturate_write();
        logic a0, a1, a2, a3, a4;
        bus_start();
        send_byte(8'h98, a0);
        send_byte(8'h13, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        send_byte(8'h33, a4);
        bus_stop();
        chk("R6 acknowledges past the top", {a0, a1, a2, a3, a4}, 5'b11111);
        chk("R6 register 13h keeps first byte", rg(19), 8'h11);
        chk("R6 register 14h holds last byte", rg(20), 8'h33);
    endtask

    task automatic t_bad_base();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h98, a0);
        send_byte(8'h15, a1);
        send_byte(8'h77, a2);
        bus_stop();
        chk("R7 device acknowledged", a0, 1);
        chk("R7 base above 14h refused", {a1, a2}, 2'b00);
        chk("R7 nothing written", rg(20), 8'h33);
    endtask

    task automatic t_read();
        logic a0, a1, a2;
        logic [7:0] b0, b1, b2, b3;
        bus_start();
        send_byte(8'h98, a0);
        send_byte(8'h02, a1);
        bus_stop();
        bus_start();
        send_byte(8'h99, a2);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        recv_byte(1'b1, b3);
        bus_stop();
        chk("R8 read address acknowledged", {a0, a1, a2}, 3'b111);
        chk("R8 first byte from pointer, MSB first (R4)", b0, 8'hA5);
        chk("R8 second byte after increment", b1, 8'h3C);
        chk("R8 third byte after increment", b2, 8'h0F);
        chk("R10 released after master nack", b3, 8'hFF);
    endtask

    task automatic t_repeated_start();
        logic a0, a1, a2, a3;
        logic [7:0] b0, b1, b2, b3;
        bus_start();
        send_byte(8'h98, a0);
        send_byte(8'h13, a1);
        bus_start();
        send_byte(8'h99, a2);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        chk("R11 acknowledges across repeated start", {a0, a1, a2}, 3'b111);
        chk("R11 pointer kept across repeated start", b0, 8'h11);
        chk("R9 read reaches 14h", b1, 8'h33);
        chk("R9 read pointer saturates at 14h", b2, 8'h33);
        bus_start();
        send_byte(8'h99, a3);
        recv_byte(1'b0, b3);
        bus_stop();
        chk("R9 saturated pointer persists", {7'd0, a3, b3}, {7'd0, 1'b1, 8'h33});
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_burst_write();
        t_no_start();
        t_select();
        t_saturate_write();
        t_bad_base();
        t_read();
        t_repeated_start();
        chk("R12 drive steady while SCL high", viol, 0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule